// File: doc/BRIEF.md
# UART Byte Stream to Word Bus Bridge

The bridge sits between a UART byte stream and a simple memory-mapped register bus. A host sends a short header: a command byte, a burst length and a four-byte word address. The bridge then performs a burst of 32-bit accesses at consecutive word addresses. For a write, the host follows the header with four bytes per word, and the bridge issues one bus write per word once that word's bytes have arrived. For a read, the bridge issues one bus read per word and returns each word to the transmitter as four bytes.

Every multi-byte field on the byte stream is big-endian: the most significant byte comes first. Receive bytes that arrive while a bus access or a transmit is in progress are dropped, because the bridge keeps no receive buffer. The host therefore paces its data to the bus and the transmitter.

Top module: `uart_bus_bridge`

## Requirements
- R1: A first header byte other than 0x01 (write) or 0x02 (read) is discarded. The parser keeps waiting for a command, and no bus access and no transmit byte results.
- R2: The second header byte is the burst length in words. The next four bytes form the 32-bit word address, most significant byte first. The first access of the burst uses that address.
- R3: For a write, each group of four received bytes, most significant byte first, forms the 32-bit `bus_wdata` of one bus access with `bus_we`=1.
- R4: For a read, each acknowledged read word is sent on `tx_data` as four bytes, most significant byte first, and `bus_we`=0 during the access.
- R5: Within a burst, each beat's word address is one greater than the previous beat's address.
- R6: A burst performs exactly the programmed number of accesses. The bridge then issues no further request and accepts a new command.
- R7: A burst length byte of 0 runs one access.
- R8: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high. The request drops in the cycle after that acknowledge.
- R9: During a read burst, the next bus request starts only after all four bytes of the current word have been accepted (`tx_valid` and `tx_ready` both high). `tx_data` is held while `tx_ready` is low, and `bus_req` and `tx_valid` are never high together.
- R10: After reset, `bus_req` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completes this cycle |

## Verification
The assertions check the handshake rules on every cycle:
- A request and its address, direction and data stay stable until acknowledged.
- A request drops after its acknowledge.
- A transmit byte is held until taken.
- A request and a transmit byte are never offered together.

The content of a transaction can only be shown by the bench's scenarios: header decoding, byte order in both directions, address stepping, burst counts, the zero-length case and the discarding of unknown commands. The bench compares the logged bus accesses and transmitted bytes against a model. The scenarios include a slow acknowledge and a stalling transmitter.

// File: rtl/uart_bus_bridge.sv
module uart_bus_bridge #(
  parameter int         ADDR_W = 32,
  parameter logic [7:0] WR_CMD = 8'h01,
  parameter logic [7:0] RD_CMD = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);

  typedef enum logic [2:0] {
    S_CMD, S_LEN, S_ADDR, S_WDAT, S_WBUS, S_RBUS, S_RTX
  } st_t;

  st_t         st;
  logic        is_wr;
  logic [7:0]  left;
  logic [1:0]  bcnt;
  logic [31:0] addr;
  logic [31:0] wsh;
  logic [31:0] rsh;

  wire last_byte = (bcnt == 2'd3);
  wire last_beat = (left == 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_CMD;
      is_wr <= 1'b0;
      left  <= 8'd1;
      bcnt  <= 2'd0;
      addr  <= '0;
      wsh   <= '0;
      rsh   <= '0;
    end else begin
      case (st)
        S_CMD: if (rx_valid) begin
          if (rx_data == WR_CMD) begin
            is_wr <= 1'b1;
            st    <= S_LEN;
          end else if (rx_data == RD_CMD) begin
            is_wr <= 1'b0;
            st    <= S_LEN;
          end
        end
        S_LEN: if (rx_valid) begin
          left <= (rx_data == 8'd0) ? 8'd1 : rx_data;
          bcnt <= 2'd0;
          st   <= S_ADDR;
        end
        S_ADDR: if (rx_valid) begin
          addr <= {addr[23:0], rx_data};
          bcnt <= bcnt + 2'd1;
          if (last_byte) st <= is_wr ? S_WDAT : S_RBUS;
        end
        S_WDAT: if (rx_valid) begin
          wsh  <= {wsh[23:0], rx_data};
          bcnt <= bcnt + 2'd1;
          if (last_byte) st <= S_WBUS;
        end
        S_WBUS: if (bus_ack) begin
          addr <= addr + 32'd1;
          left <= left - 8'd1;
          st   <= last_beat ? S_CMD : S_WDAT;
        end
        S_RBUS: if (bus_ack) begin
          rsh  <= bus_rdata;
          bcnt <= 2'd0;
          st   <= S_RTX;
        end
        S_RTX: if (tx_ready) begin
          rsh  <= {rsh[23:0], 8'h00};
          bcnt <= bcnt + 2'd1;
          if (last_byte) begin
            addr <= addr + 32'd1;
            left <= left - 8'd1;
            st   <= last_beat ? S_CMD : S_RBUS;
          end
        end
        default: st <= S_CMD;
      endcase
    end
  end

  assign bus_req   = (st == S_WBUS) || (st == S_RBUS);
  assign bus_we    = (st == S_WBUS);
  assign bus_addr  = addr[ADDR_W-1:0];
  assign bus_wdata = wsh;
  assign tx_valid  = (st == S_RTX);
  assign tx_data   = rsh[31:24];

endmodule

module uart_bus_bridge_chk #(parameter int ADDR_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_ready,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack
);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && tx_valid));

  p_read_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !(bus_req && bus_we));

endmodule

bind uart_bus_bridge uart_bus_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/test_uart_bus_bridge.sv
module test_uart_bus_bridge;
  logic clk = 0;
  logic rst_n = 0;
  logic rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic bus_req, bus_we, bus_ack = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;

  always #2.5 clk = ~clk;

  uart_bus_bridge i_uart_bus_bridge (.*);

  int checks = 0, fails = 0;
  int n_acc = 0, n_tx = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_wd   [64];
  logic        log_we   [64];
  int          log_txn  [64];
  logic [7:0]  tx_log   [256];
  int ack_dly = 0;
  int wcnt = 0;
  bit tx_stall = 0;
  int rcnt = 0;

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h0BADF00D;
  endfunction

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 0;
    end else if (bus_req) begin
      if (wcnt >= ack_dly) begin
        bus_ack = 1;
        bus_rdata = rd_model(bus_addr);
        if (n_acc < 64) begin
          log_addr[n_acc] = bus_addr;
          log_wd[n_acc]   = bus_wdata;
          log_we[n_acc]   = bus_we;
          log_txn[n_acc]  = n_tx;
        end
        n_acc++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  always @(negedge clk) begin
    rcnt++;
    tx_ready = !tx_stall || (rcnt % 3 == 0);
    if (tx_valid && tx_ready) begin
      if (n_tx < 256) tx_log[n_tx] = tx_data;
      n_tx++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_hdr(input logic [7:0] cmd, input logic [7:0] len,
                          input logic [31:0] a);
    send_byte(cmd);
    send_byte(len);
    for (int k = 3; k >= 0; k--) send_byte(a[8*k +: 8]);
  endtask

  task automatic wait_acc(input int n);
    for (int t = 0; t < 3000 && n_acc < n; t++) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    for (int t = 0; t < 6000 && n_tx < n; t++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] len, input logic [31:0] a, input string req);
    int base = n_acc;
    int beats = (len == 0) ? 1 : len;
    send_hdr(8'h01, len, a);
    for (int i = 0; i < beats; i++) begin
      logic [31:0] w = 32'hC0DE0000 + a[15:0] * 16 + i;
      for (int k = 3; k >= 0; k--) send_byte(w[8*k +: 8]);
      wait_acc(base + i + 1);
    end
    repeat (20) @(negedge clk);
    check(n_acc == base + beats, req, "write access count (R6)", n_acc - base, beats);
    for (int i = 0; i < beats; i++) begin
      logic [31:0] w = 32'hC0DE0000 + a[15:0] * 16 + i;
      check(log_addr[base+i] == a + i, req, "write address (R2/R5)", log_addr[base+i], a + i);
      check(log_wd[base+i] == w, "R3", "write data msb first", log_wd[base+i], w);
      check(log_we[base+i] == 1'b1, "R3", "write enable", log_we[base+i], 1);
    end
    check(!bus_req && !tx_valid, "R6", "idle after write burst", {bus_req, tx_valid}, 0);
  endtask

  task automatic do_read(input logic [7:0] len, input logic [31:0] a, input string req);
    int base = n_acc;
    int tbase = n_tx;
    int beats = (len == 0) ? 1 : len;
    send_hdr(8'h02, len, a);
    wait_tx(tbase + 4 * beats);
    repeat (20) @(negedge clk);
    check(n_acc == base + beats, req, "read access count (R6)", n_acc - base, beats);
    check(n_tx == tbase + 4 * beats, "R4", "tx byte count", n_tx - tbase, 4 * beats);
    for (int i = 0; i < beats; i++) begin
      logic [31:0] exp = rd_model(a + i);
      logic [31:0] got = {tx_log[tbase+4*i], tx_log[tbase+4*i+1],
                          tx_log[tbase+4*i+2], tx_log[tbase+4*i+3]};
      check(log_addr[base+i] == a + i, req, "read address (R2/R5)", log_addr[base+i], a + i);
      check(log_we[base+i] == 1'b0, "R4", "read direction", log_we[base+i], 0);
      check(got == exp, "R4", "read bytes msb first", got, exp);
      check(log_txn[base+i] == tbase + 4 * i, "R9", "beat waits for 4 tx bytes",
            log_txn[base+i] - tbase, 4 * i);
    end
    check(!bus_req && !tx_valid, "R6", "idle after read burst", {bus_req, tx_valid}, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!bus_req, "R10", "bus_req in reset", bus_req, 0);
    check(!tx_valid, "R10", "tx_valid in reset", tx_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!bus_req && !tx_valid, "R10", "idle after reset", {bus_req, tx_valid}, 0);
  endtask

  task automatic t_bad_cmd;
    int a0 = n_acc, t0 = n_tx;
    send_byte(8'hFF);
    send_byte(8'h00);
    send_byte(8'h7E);
    repeat (20) @(negedge clk);
    check(n_acc == a0 && !bus_req, "R1", "no access after unknown command", n_acc - a0, 0);
    check(n_tx == t0 && !tx_valid, "R1", "no tx after unknown command", n_tx - t0, 0);
    do_write(8'd1, 32'h0000_0040, "R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_bad_cmd();
    do_write(8'd3, 32'h1234_5678, "R2");
    do_read(8'd2, 32'hA0B1_C2D3, "R5");
    do_write(8'd0, 32'h0000_0100, "R7");
    do_read(8'd0, 32'h0000_0200, "R7");
    ack_dly = 5;
    do_write(8'd2, 32'h0000_FFFF, "R8");
    tx_stall = 1;
    do_read(8'd3, 32'hFFFF_FFFE, "R9");
    ack_dly = 0;
    tx_stall = 0;
    do_read(8'd1, 32'h0000_0300, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule